// File: doc/BRIEF.md
# Dual-Channel Serial Converter Output Emulator

This block stands in for the digital side of a two-channel, simultaneous-sampling 12-bit converter, so that a host's serial receive logic can be exercised without any analog hardware. The host drives an active-low chip select and a serial clock. The block returns one serial data line and an enable that marks when the line is driven, taking the place of a tri-state pad. Two parallel 12-bit two's-complement sample buses supply the values the converter would have measured.

Both asynchronous host signals pass through synchronizer flops and are oversampled by the fast system clock. The block counts serial-clock falling edges inside each 32-edge conversion. It captures both channels at the same moment and puts out, MSB first, a zero-padded result for channel A and then one for channel B. While chip select stays low, conversions follow one another directly. Raising chip select at any point stops the current conversion and releases the line.

Top module: `dsadc_emu`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe` is 0 and `sdo` is 0. While it is low, `sdo_oe` is 1.
- R2: Within a conversion, the value on `sdo` after falling edge k is 0 for k = 1 to 4. For k = 5 to 16 it is bit (16 − k) of the channel A result, so the MSB comes first.
- R3: After falling edge k, `sdo` is 0 for k = 17 to 20. For k = 21 to 32 it is bit (32 − k) of the channel B result.
- R4: Both sample buses are captured together on falling edge 4. Later changes on the buses do not alter the bits shifted out in that conversion.
- R5: While chip select stays low, the falling edge after edge 32 becomes edge 1 of a new conversion. That conversion samples again on its own edge 4.
- R6: Raising chip select in the middle of a conversion disables the output at once. The next chip-select fall starts a new conversion from edge 1.
- R7: If the serial clock is low when chip select falls, that fall counts as edge 1. If the serial clock is high, edge 1 is the next serial-clock fall.
- R8: Results are shifted out exactly as the 12-bit two's-complement pattern on the bus, including the extreme codes 0x800 and 0x7FF.
- R9: After synchronous reset, `sdo_oe` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host signals |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| smp_a | input | 12 | Channel A sample, two's complement |
| smp_b | input | 12 | Channel B sample, two's complement |
| sdo | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe | output | 1 | High while `sdo` would be driven |

## Verification
The assertions check several rules on every cycle: the line stays quiet while disabled, the edge count never goes past 32 and returns to 1 after edge 32, the lead-in slots are zero, and the holding registers take the bus values at the edge-4 capture. Other behaviour can only be shown by the directed scenarios. These cover the exact bit order of both channel results, how the two chip-select/clock start conditions are told apart, resistance to bus changes after sampling, abort and restart, back-to-back conversions with fresh samples, and the extreme codes.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    localparam int RES_W       = 12;
    localparam int LEAD_ZEROS  = 4;
    localparam int HALF_LEN    = RES_W + LEAD_ZEROS;
    localparam int FRAME_LEN   = 2 * HALF_LEN;
    localparam int SAMPLE_EDGE = LEAD_ZEROS;
    localparam int CNT_W       = $clog2(FRAME_LEN + 1);

    typedef logic [CNT_W-1:0] edge_cnt_t;

    typedef struct packed {
        logic [RES_W-1:0] cha;
        logic [RES_W-1:0] chb;
    } sample_pair_t;

    // Bit placed on the line after falling edge k of a conversion.
    function automatic logic frame_bit(input edge_cnt_t k, input sample_pair_t p);
        int               kk;
        logic [RES_W-1:0] sh;
        kk = int'(k);
        frame_bit = 1'b0;
        if (kk > LEAD_ZEROS && kk <= HALF_LEN) begin
            sh = p.cha >> (HALF_LEN - kk);
            frame_bit = sh[0];
        end else if (kk > HALF_LEN + LEAD_ZEROS && kk <= FRAME_LEN) begin
            sh = p.chb >> (FRAME_LEN - kk);
            frame_bit = sh[0];
        end
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q,
    output logic fell
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){RST_VAL}};
        else     chain <= {chain[STAGES-1:0], d_in};
    end

    assign q    = chain[STAGES-1];
    assign fell = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/dsadc_frame_ctr.sv
module dsadc_frame_ctr
    import dsadc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_lvl,
    input  logic      cs_fell,
    input  logic      sclk_lvl,
    input  logic      sclk_fell,
    output edge_cnt_t edge_cnt,
    output logic      capture
);
    localparam edge_cnt_t LAST = edge_cnt_t'(FRAME_LEN);
    localparam edge_cnt_t SMP  = edge_cnt_t'(SAMPLE_EDGE);
    localparam edge_cnt_t ONE  = edge_cnt_t'(1);

    edge_cnt_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cs_lvl)
            cnt_d = '0;
        else if (cs_fell)
            cnt_d = sclk_lvl ? '0 : ONE;
        else if (sclk_fell)
            cnt_d = (cnt_q == LAST) ? ONE : cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign edge_cnt = cnt_q;
    assign capture  = !cs_lvl && (cnt_d == SMP) && (cnt_q != SMP);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!cs_lvl && !cs_fell && sclk_fell && cnt_q == LAST) |=> (cnt_q == ONE));

    p_idle_clear_r1: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> (cnt_q == '0));
endmodule

// File: rtl/dsadc_shifter.sv
module dsadc_shifter
    import dsadc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         active,
    input  edge_cnt_t    edge_cnt,
    input  sample_pair_t smp,
    output logic         sdo
);
    sample_pair_t hold_q;

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (capture) hold_q <= smp;
    end

    assign sdo = active ? frame_bit(edge_cnt, hold_q) : 1'b0;

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        capture |=> (hold_q == $past(smp)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(hold_q));
endmodule

// File: rtl/dsadc_emu.sv
module dsadc_emu
    import dsadc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] smp_a,
    input  logic [RES_W-1:0] smp_b,
    output logic             sdo,
    output logic             sdo_oe
);
    logic         cs_lvl, cs_fell, sclk_lvl, sclk_fell, capture;
    edge_cnt_t    edge_cnt;
    sample_pair_t smp;

    assign smp.cha = smp_a;
    assign smp.chb = smp_b;

    dsadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .d_in(cs_n), .q(cs_lvl), .fell(cs_fell));

    dsadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst(rst), .d_in(sclk), .q(sclk_lvl), .fell(sclk_fell));

    dsadc_frame_ctr u_ctr (
        .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_fell(cs_fell),
        .sclk_lvl(sclk_lvl), .sclk_fell(sclk_fell),
        .edge_cnt(edge_cnt), .capture(capture));

    dsadc_shifter u_shf (
        .clk(clk), .rst(rst), .capture(capture), .active(!cs_lvl),
        .edge_cnt(edge_cnt), .smp(smp), .sdo(sdo));

    assign sdo_oe = !cs_lvl;

    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

    p_lead_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (edge_cnt >= edge_cnt_t'(1) && edge_cnt <= edge_cnt_t'(LEAD_ZEROS)) |-> !sdo);
endmodule

// File: tb/dsadc_emu_tb.sv
module dsadc_emu_tb;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] smp_a = '0;
    logic [11:0] smp_b = '0;
    logic        sdo, sdo_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    dsadc_emu u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .smp_a(smp_a), .smp_b(smp_b), .sdo(sdo), .sdo_oe(sdo_oe));

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic exp_bit(input int k, input logic [11:0] a, input logic [11:0] b);
        if (k >= 5 && k <= 16) return a[16 - k];
        if (k >= 21 && k <= 32) return b[32 - k];
        return 1'b0;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_fall();
        @(negedge clk) sclk = 1'b0;
        wait_clk(HP);
    endtask

    task automatic sclk_rise();
        @(negedge clk) sclk = 1'b1;
        wait_clk(HP);
    endtask

    // Edges first_k..last_k; bus scrambled after edge 4 to probe R4.
    task automatic run_edges(input int first_k, input int last_k,
                             input logic [11:0] a, input logic [11:0] b,
                             input logic scramble);
        for (int k = first_k; k <= last_k; k++) begin
            sclk_fall();
            if (k <= 16) chk("R2", sdo, exp_bit(k, a, b));
            else         chk("R3", sdo, exp_bit(k, a, b));
            if (k == 4 && scramble) begin
                smp_a = ~a;
                smp_b = ~b;
            end
            sclk_rise();
        end
    endtask

    task automatic t_reset();
        chk("R9 oe", sdo_oe, 1'b0);
        chk("R9 sdo", sdo, 1'b0);
    endtask

    task automatic t_single_high_start(input logic [11:0] a, input logic [11:0] b);
        smp_a = a; smp_b = b;
        @(negedge clk) cs_n = 1'b0;
        wait_clk(HP);
        chk("R1 oe low cs", sdo_oe, 1'b1);
        chk("R7 no edge yet", sdo, 1'b0);
        run_edges(1, 32, a, b, 1'b1);
        @(negedge clk) cs_n = 1'b1;
        wait_clk(HP);
        chk("R1 oe", sdo_oe, 1'b0);
        chk("R1 sdo", sdo, 1'b0);
    endtask

    task automatic t_low_start(input logic [11:0] a, input logic [11:0] b);
        smp_a = a; smp_b = b;
        sclk_fall();
        @(negedge clk) cs_n = 1'b0;
        wait_clk(HP);
        chk("R7 edge1", sdo, 1'b0);
        sclk_rise();
        run_edges(2, 32, a, b, 1'b1);
        @(negedge clk) cs_n = 1'b1;
        wait_clk(HP);
        chk("R1 oe", sdo_oe, 1'b0);
    endtask

    task automatic t_continuous();
        smp_a = 12'h5A3; smp_b = 12'h0C7;
        @(negedge clk) cs_n = 1'b0;
        wait_clk(HP);
        run_edges(1, 32, 12'h5A3, 12'h0C7, 1'b0);
        smp_a = 12'h9E1; smp_b = 12'h3B4;
        run_edges(1, 32, 12'h9E1, 12'h3B4, 1'b1);
        chk("R5 oe", sdo_oe, 1'b1);
        @(negedge clk) cs_n = 1'b1;
        wait_clk(HP);
    endtask

    task automatic t_abort();
        smp_a = 12'hFFF; smp_b = 12'hFFF;
        @(negedge clk) cs_n = 1'b0;
        wait_clk(HP);
        run_edges(1, 10, 12'hFFF, 12'hFFF, 1'b0);
        @(negedge clk) cs_n = 1'b1;
        wait_clk(HP);
        chk("R6 oe", sdo_oe, 1'b0);
        chk("R6 sdo", sdo, 1'b0);
        smp_a = 12'h123; smp_b = 12'h456;
        @(negedge clk) cs_n = 1'b0;
        wait_clk(HP);
        run_edges(1, 32, 12'h123, 12'h456, 1'b0);
        @(negedge clk) cs_n = 1'b1;
        wait_clk(HP);
    endtask

    task automatic t_extremes();
        t_single_high_start(12'h800, 12'h7FF);
        t_single_high_start(12'h7FF, 12'h800);
        chk("R8 idle", sdo, 1'b0);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        @(negedge clk) rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_single_high_start(12'hA5C, 12'h36F);
        t_low_start(12'hC3A, 12'h5E9);
        t_continuous();
        t_abort();
        t_extremes();
        finish_run();
    end
endmodule